// File: doc/BRIEF.md
# CAN Bus Error Capture Register

This block is a read-only status register for a CAN controller. When the bit-processing logic reports a bus error, the block stores three things: the kind of error, whether the node was sending or receiving, and a 5-bit code for the frame segment where the error was found. Software then reads these fields from one 32-bit word.

The register keeps the first error it sees. After a capture it holds its contents and a lock flag. Any further error reports are dropped until the CPU reads the word, and that read arms the register again. Software therefore always sees the error that started a burst, not the last one in it. An error that is actually captured can also raise a one-cycle bus-error interrupt pulse, but only while the interrupt enable input is high.

If an error report and a CPU read land in the same cycle, the read returns the old word. The new error is stored at the clock edge, and the register is locked again.

Top module: `can_err_capture`

## Requirements
- R1: After synchronous active-low reset, `rd_data` is all zeros and `irq` is 0.
- R2: An error strobe while the register is armed stores the error at the clock edge. From the next cycle `rd_data[7:6]` holds the code (00 bit, 01 form, 10 stuff, 11 other), `rd_data[5]` holds the direction (0 transmit, 1 receive) and `rd_data[4:0]` holds the segment code.
- R3: While locked, an error strobe with no read in the same cycle leaves `rd_data` unchanged and produces no `irq` pulse.
- R4: A CPU read arms the register, so the next error strobe is captured as in R2.
- R5: If an error strobe and a read occur in the same cycle, `rd_data` in that cycle shows the old contents. From the next cycle it shows the new error, and the register is locked, so a later strobe with no read is ignored.
- R6: `rd_data[31:8]` always reads 0. The block has no write port.
- R7: `irq` is high for exactly the one cycle after a captured strobe, and only if `irq_en` was 1 in the strobe cycle. An ignored strobe, or a strobe with `irq_en` at 0, gives no pulse.
- R8: A read with no error strobe does not change `rd_data`, either in the read cycle or after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_stb | input | 1 | One-cycle bus error report from the bit processor |
| err_code | input | 2 | Error kind: 00 bit, 01 form, 10 stuff, 11 other |
| err_rx | input | 1 | Direction: 0 while transmitting, 1 while receiving |
| err_seg | input | 5 | Frame segment code at the time of the error |
| irq_en | input | 1 | Bus-error interrupt enable |
| rd_stb | input | 1 | CPU read of the register in this cycle |
| rd_data | output | 32 | Register contents: zeros above bit 7, then code, direction and segment |
| irq | output | 1 | One-cycle bus-error interrupt pulse |

## Verification
A lock flag stuck at 0 lets a second error overwrite the held word. This shows at `rd_data` one cycle after that strobe, together with an extra `irq` pulse. A lock flag stuck at 1, or a read that fails to clear it, makes the next error after a read disappear. That is visible one cycle after the strobe. A wrong order of field concatenation, or a read path that sees the new error too early, shows at once in the bit pattern of `rd_data`. The bench runs through every combination of code, direction and segment, so each field bit is tested at both values.

// File: rtl/can_err_pkg.sv
// Package: shared field widths and the error kind encoding for the
// CAN bus error capture register. Assumes a 2-bit error kind field.
package can_err_pkg;
    localparam int ERR_CODE_W = 2;
    localparam int ERR_SEG_W  = 5;

    typedef enum logic [ERR_CODE_W-1:0] {
        ERR_BIT   = 2'b00,
        ERR_FORM  = 2'b01,
        ERR_STUFF = 2'b10,
        ERR_OTHER = 2'b11
    } err_kind_e;
endpackage

// File: rtl/can_ecc_latch.sv
// Module: first-error latch. It holds one error record and a lock flag.
// A strobe is taken when the latch is unlocked, or when a read in the
// same cycle releases it. A read with no strobe only clears the lock.
// Assumes err_stb and rd_stb are single-cycle qualifiers.
module can_ecc_latch #(
    parameter int CODE_W = 2,
    parameter int SEG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_stb,
    input  logic [CODE_W-1:0] err_code,
    input  logic              err_rx,
    input  logic [SEG_W-1:0]  err_seg,
    input  logic              rd_stb,
    output logic [CODE_W-1:0] held_code,
    output logic              held_rx,
    output logic [SEG_W-1:0]  held_seg,
    output logic              locked,
    output logic              take
);
    // Decide whether this strobe is allowed to load the record.
    always_comb take = err_stb && (!locked || rd_stb);

    // Load the error record on an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_code <= '0;
            held_rx   <= 1'b0;
            held_seg  <= '0;
        end else if (take) begin
            held_code <= err_code;
            held_rx   <= err_rx;
            held_seg  <= err_seg;
        end
    end

    // Lock on capture; a read with no capture re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n)      locked <= 1'b0;
        else if (take)   locked <= 1'b1;
        else if (rd_stb) locked <= 1'b0;
    end
endmodule

// File: rtl/can_ecc_irq.sv
// Module: bus-error interrupt pulse. It gives one registered cycle per
// captured error when the enable is set. Assumes take is one cycle wide.
module can_ecc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic irq_en,
    output logic irq
);
    // Register the gated capture event as the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= take && irq_en;
    end
endmodule

// File: rtl/can_ecc_rdfmt.sv
// Module: read word formatter. It packs the held record into the low
// bits of the data word and fills the rest with zeros. Assumes
// CODE_W + 1 + SEG_W <= DATA_W.
module can_ecc_rdfmt #(
    parameter int CODE_W = 2,
    parameter int SEG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [CODE_W-1:0] held_code,
    input  logic              held_rx,
    input  logic [SEG_W-1:0]  held_seg,
    output logic [DATA_W-1:0] rd_data
);
    localparam int INFO_W = CODE_W + 1 + SEG_W;
    localparam int PAD_W  = DATA_W - INFO_W;

    generate
        if (PAD_W > 0) begin : g_pad
            // Zero-fill the reserved upper bits.
            always_comb rd_data = {{PAD_W{1'b0}}, held_code, held_rx, held_seg};
        end else begin : g_nopad
            // Exact fit: no reserved bits.
            always_comb rd_data = {held_code, held_rx, held_seg};
        end
    endgenerate
endmodule

// File: rtl/can_err_capture.sv
// Module: top of the CAN bus error capture register. It ties together
// the first-error latch, the interrupt pulse and the read formatter.
// Assumes the bit processor presents error fields together with err_stb.
module can_err_capture #(
    parameter int CODE_W = can_err_pkg::ERR_CODE_W,
    parameter int SEG_W  = can_err_pkg::ERR_SEG_W,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_stb,
    input  logic [CODE_W-1:0] err_code,
    input  logic              err_rx,
    input  logic [SEG_W-1:0]  err_seg,
    input  logic              irq_en,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [CODE_W-1:0] held_code;
    logic              held_rx;
    logic [SEG_W-1:0]  held_seg;
    logic              locked;
    logic              take;

    can_ecc_latch #(.CODE_W(CODE_W), .SEG_W(SEG_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .err_stb(err_stb), .err_code(err_code),
        .err_rx(err_rx), .err_seg(err_seg), .rd_stb(rd_stb),
        .held_code(held_code), .held_rx(held_rx), .held_seg(held_seg),
        .locked(locked), .take(take)
    );

    can_ecc_irq u_irq (
        .clk(clk), .rst_n(rst_n), .take(take), .irq_en(irq_en), .irq(irq)
    );

    can_ecc_rdfmt #(.CODE_W(CODE_W), .SEG_W(SEG_W), .DATA_W(DATA_W)) u_fmt (
        .held_code(held_code), .held_rx(held_rx), .held_seg(held_seg),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/can_err_capture_chk.sv
// Module: assertion checker for can_err_capture, attached with bind.
module can_err_capture_chk #(
    parameter int CODE_W = 2,
    parameter int SEG_W  = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_stb,
    input logic [CODE_W-1:0] err_code,
    input logic              err_rx,
    input logic [SEG_W-1:0]  err_seg,
    input logic              irq_en,
    input logic              rd_stb,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq,
    input logic              locked
);
    localparam int INFO_W = CODE_W + 1 + SEG_W;

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_stb && !locked) |=> rd_data[INFO_W-1:0] ==
            {$past(err_code), $past(err_rx), $past(err_seg)});

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !rd_stb) |=> $stable(rd_data));

    assert_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !err_stb) |=> !locked);

    assert_relock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_stb |=> locked);

    assert_resv_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:INFO_W] == '0);

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_stb || !irq_en || (locked && !rd_stb)) |=> !irq);

    assert_irq_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_stb && irq_en && (!locked || rd_stb)) |=> irq);
endmodule

bind can_err_capture can_err_capture_chk #(
    .CODE_W(CODE_W), .SEG_W(SEG_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .err_stb(err_stb), .err_code(err_code),
    .err_rx(err_rx), .err_seg(err_seg), .irq_en(irq_en), .rd_stb(rd_stb),
    .rd_data(rd_data), .irq(irq), .locked(locked)
);

// File: tb/can_err_capture_tb.sv
`timescale 1ns/1ps
// Bench: sweeps all 256 code/direction/segment values through capture,
// hold, read, same-cycle read+error and relock sequences.
module can_err_capture_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_stb = 1'b0;
    logic [1:0]  err_code = '0;
    logic        err_rx = 1'b0;
    logic [4:0]  err_seg = '0;
    logic        irq_en = 1'b0;
    logic        rd_stb = 1'b0;
    logic [31:0] rd_data;
    logic        irq;
    int          checks = 0;
    int          failures = 0;
    logic [31:0] pre;

    always #4 clk = ~clk;

    can_err_capture u_dut (
        .clk(clk), .rst_n(rst_n), .err_stb(err_stb), .err_code(err_code),
        .err_rx(err_rx), .err_seg(err_seg), .irq_en(irq_en), .rd_stb(rd_stb),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge: drive inputs, sample pre-edge rd_data,
    // then wait to the next negedge.
    task automatic cyc(input logic stb, input logic [7:0] v, input logic rd, input logic en);
        err_stb  = stb;
        err_code = v[7:6];
        err_rx   = v[5];
        err_seg  = v[4:0];
        rd_stb   = rd;
        irq_en   = en;
        #1 pre = rd_data;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired (all requirements)");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rd_data, 32'h0, "R1 reset data");
        check({31'b0, irq}, 32'h0, "R1 reset irq");
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            logic [7:0] v, w, nx, nx2;
            logic en;
            v   = 8'(i);
            w   = ~v;
            nx  = 8'(i + 1);
            nx2 = 8'(i + 2);
            en  = v[0] ^ v[3];
            // armed capture (also exercises re-arm after previous read, R4)
            cyc(1'b1, v, 1'b0, en);
            check(rd_data, {24'b0, v}, "R2/R4 capture fields");
            check(rd_data & 32'hFFFFFF00, 32'h0, "R6 upper bits zero");
            check({31'b0, irq}, {31'b0, en}, "R7 irq pulse gated by enable");
            // ignored strobe while locked
            cyc(1'b1, w, 1'b0, 1'b1);
            check(rd_data, {24'b0, v}, "R3 hold while locked");
            check({31'b0, irq}, 32'h0, "R3 no irq on ignored error");
            // idle: pulse has ended
            cyc(1'b0, 8'h00, 1'b0, 1'b0);
            check({31'b0, irq}, 32'h0, "R7 single-cycle pulse");
            // plain read
            cyc(1'b0, 8'h00, 1'b1, 1'b0);
            check(pre, {24'b0, v}, "R8 read cycle data");
            check(rd_data, {24'b0, v}, "R8 after read data");
            // read and strobe together
            cyc(1'b1, nx, 1'b1, 1'b0);
            check(pre, {24'b0, v}, "R5 read returns old");
            check(rd_data, {24'b0, nx}, "R5 new error captured");
            // locked again
            cyc(1'b1, nx2, 1'b0, 1'b1);
            check(rd_data, {24'b0, nx}, "R5 relocked after collision");
            check({31'b0, irq}, 32'h0, "R5 no irq while relocked");
            // read to re-arm
            cyc(1'b0, 8'h00, 1'b1, 1'b0);
        end
        // reset mid-run
        cyc(1'b1, 8'hA5, 1'b0, 1'b1);
        rst_n = 1'b0;
        cyc(1'b0, 8'h00, 1'b0, 1'b0);
        check(rd_data, 32'h0, "R1 reset clears data");
        check({31'b0, irq}, 32'h0, "R1 reset clears irq");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule